// File: doc/BRIEF.md
# Chunked Expansion-Memory Copy Engine

This block copies bytes between an 8-bit host bus and a large external expansion SRAM. A CPU programs a 16-bit host pointer, a 24-bit expansion pointer and a control byte, all through a small register window. Setting the go bit in the control byte moves exactly one chunk, whose length is a power of two from 1 to 128 bytes. While the chunk moves, the engine holds the CPU stopped and owns both memory ports. It moves one byte per clock once the bus is granted.

At the end of a chunk, both pointers stay advanced past the data already moved. Software can therefore move a large block by writing the same control byte again and again. Software also handles any host banking between chunks. The host side can instead be held at one fixed address, so a stream can be poured into, or drained from, a single port location.

Both memories are modelled as simple synchronous RAMs: read data appears one clock after the address. The expansion memory uses `EXP_AW` address bits (19 by default). The remaining bits of the 24-bit pointer are stored but never change on their own.

Top module: `chunk_dma`

## Requirements
- R1: After reset, all six registers read 0. `cpu_halt` and `bus_req` are low, and neither memory write strobe is active.
- R2: Register window by `cpu_addr`: 0 = control, 1/2 = host pointer low/high byte, 3/4/5 = expansion pointer low/mid/high byte. Addresses 6 and 7 read 0 and ignore writes. Every register reads back what was last written. Control bits 7:6 are spare: they read back as written and change no transfer. A control write with bit 0 clear starts nothing.
- R3: Control layout: bit 0 = go, bits 3:1 = size code, bit 4 = hold host address, bit 5 = direction. A control write with bit 0 set while idle raises `cpu_halt` and `bus_req` from the next clock. The go bit reads 1 until the chunk ends and then 0. `cpu_halt` and `bus_req` fall together on the clock that completes the last write.
- R4: No memory write takes place before `bus_gnt` is sampled high.
- R5: A chunk with size code c writes exactly 2^c bytes (code 0 = 1 byte, code 7 = 128 bytes).
- R6: Direction bit 0 copies host memory into expansion memory. Direction bit 1 copies expansion memory into host memory. Byte k of the chunk is read from source pointer + k and written to destination pointer + k.
- R7: With the hold bit set, every host-side access of the chunk uses the host pointer value, and the host pointer is unchanged afterwards. The expansion side still increments.
- R8: After a chunk of n bytes, the expansion pointer reads n higher, and the host pointer reads n higher (or the same, when held). Writing the same control byte again continues the copy from where it stopped.
- R9: The host pointer wraps modulo 2^16. The low `EXP_AW` bits of the expansion pointer wrap modulo 2^EXP_AW, and its bits above `EXP_AW` keep their written value.
- R10: Register writes that arrive while a chunk is in progress are ignored.
- R11: The go write is taken at clock edge E0, and `bus_gnt` is first sampled high at edge G. The first read happens at G+1, byte k is written at G+2+k, and `cpu_halt` is high for (G−E0)+n+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register select |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data (combinational) |
| cpu_halt | output | 1 | Holds the CPU stopped while a chunk is in progress |
| bus_req | output | 1 | Requests the memory buses |
| bus_gnt | input | 1 | Memory buses granted |
| hm_addr | output | 16 | Host memory address |
| hm_wdata | output | 8 | Host memory write data |
| hm_we | output | 1 | Host memory write enable |
| hm_rdata | input | 8 | Host memory read data, one clock after the address |
| xm_addr | output | EXP_AW | Expansion memory address |
| xm_wdata | output | 8 | Expansion memory write data |
| xm_we | output | 1 | Expansion memory write enable |
| xm_rdata | input | 8 | Expansion memory read data, one clock after the address |

## Verification
The hardest case to reach is the wrap of the expansion pointer at its top boundary while its spare high bits are set. The host pointer wrapping in the same chunk is equally hard to reach. The bench loads both pointers a few bytes below their limits, with nonzero spare bits, and runs chunks in both directions. It then checks every logged write address and reads the pointers back.

Stray register writes during a transfer are also hard to provoke, because a real CPU would be stopped. The bench drives the write port on every halted cycle and then confirms through readback that nothing changed. The bench also varies the grant delay over a sweep of every size code, direction and hold setting, so the exact chunk duration is checked against the arithmetic.

// File: rtl/chunk_dma.sv
module chunk_dma #(
  parameter int EXP_AW = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [2:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_halt,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [15:0]       hm_addr,
  output logic [7:0]        hm_wdata,
  output logic              hm_we,
  input  logic [7:0]        hm_rdata,
  output logic [EXP_AW-1:0] xm_addr,
  output logic [7:0]        xm_wdata,
  output logic              xm_we,
  input  logic [7:0]        xm_rdata
);
  localparam int XW = 24;
  localparam logic [XW-1:0] XMASK = XW'((64'd1 << EXP_AW) - 64'd1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} st_t;

  st_t               st;
  logic [7:0]        ctrl;
  logic [15:0]       hptr;
  logic [XW-1:0]     xptr;
  logic [7:0]        left;
  logic              wr_v;
  logic [15:0]       h_q;
  logic [EXP_AW-1:0] x_q;

  wire busy     = (st != S_IDLE);
  wire hold_h   = ctrl[4];
  wire x2h      = ctrl[5];
  wire rd_go    = (st == S_RUN) && (left != 8'd0);
  wire fin      = (st == S_RUN) && wr_v && (left == 8'd0);
  wire [XW-1:0] xinc = (xptr & ~XMASK) | ((xptr + 24'd1) & XMASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ctrl <= '0;
      hptr <= '0;
      xptr <= '0;
      left <= '0;
      wr_v <= 1'b0;
      h_q  <= '0;
      x_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (cpu_we) begin
          case (cpu_addr)
            3'd0: begin
              ctrl <= cpu_wdata;
              if (cpu_wdata[0]) begin
                st   <= S_WAIT;
                left <= 8'd1 << cpu_wdata[3:1];
              end
            end
            3'd1: hptr[7:0]   <= cpu_wdata;
            3'd2: hptr[15:8]  <= cpu_wdata;
            3'd3: xptr[7:0]   <= cpu_wdata;
            3'd4: xptr[15:8]  <= cpu_wdata;
            3'd5: xptr[23:16] <= cpu_wdata;
            default: ;
          endcase
        end
        S_WAIT: if (bus_gnt) st <= S_RUN;
        S_RUN: begin
          wr_v <= rd_go;
          if (rd_go) begin
            left <= left - 8'd1;
            h_q  <= hptr;
            x_q  <= xptr[EXP_AW-1:0];
            xptr <= xinc;
            if (!hold_h) hptr <= hptr + 16'd1;
          end
          if (fin) begin
            st      <= S_IDLE;
            ctrl[0] <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (cpu_addr)
      3'd0:    cpu_rdata = ctrl;
      3'd1:    cpu_rdata = hptr[7:0];
      3'd2:    cpu_rdata = hptr[15:8];
      3'd3:    cpu_rdata = xptr[7:0];
      3'd4:    cpu_rdata = xptr[15:8];
      3'd5:    cpu_rdata = xptr[23:16];
      default: cpu_rdata = 8'h00;
    endcase
  end

  assign cpu_halt = busy;
  assign bus_req  = busy;
  assign hm_we    = wr_v && x2h;
  assign xm_we    = wr_v && !x2h;
  assign hm_addr  = hm_we ? h_q : hptr;
  assign xm_addr  = xm_we ? x_q : xptr[EXP_AW-1:0];
  assign hm_wdata = xm_rdata;
  assign xm_wdata = hm_rdata;

endmodule

// File: rtl/chunk_dma_chk.sv
module chunk_dma_chk #(
  parameter int EXP_AW = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic [2:0]        cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_halt,
  input logic              bus_gnt,
  input logic              hm_we,
  input logic              xm_we,
  input logic [15:0]       hm_addr,
  input logic [EXP_AW-1:0] xm_addr,
  input logic [7:0]        ctrl
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_halt |-> (!hm_we && !xm_we)); // R1

  AST_GO_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_halt && cpu_we && cpu_addr == 3'd0 && cpu_wdata[0]) |=> cpu_halt); // R3

  AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> ctrl[0]); // R3

  AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (hm_we || xm_we) |-> (bus_gnt && cpu_halt)); // R4

  AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hm_we, xm_we}) && (!hm_we || ctrl[5]) && (!xm_we || !ctrl[5])); // R6

  AST_HELD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (hm_we && $past(hm_we) && ctrl[4]) |-> $stable(hm_addr)); // R7

  AST_HOST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hm_we && $past(hm_we) && !ctrl[4]) |-> (hm_addr == 16'($past(hm_addr) + 16'd1))); // R9

  AST_EXP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xm_we && $past(xm_we)) |-> (xm_addr == EXP_AW'($past(xm_addr) + 1'b1))); // R9

  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt && $past(cpu_halt)) |-> $stable(ctrl[7:1])); // R10
endmodule

bind chunk_dma chunk_dma_chk #(.EXP_AW(EXP_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .cpu_halt(cpu_halt), .bus_gnt(bus_gnt),
  .hm_we(hm_we), .xm_we(xm_we), .hm_addr(hm_addr), .xm_addr(xm_addr),
  .ctrl(ctrl)
);

// File: tb/sim_chunk_dma.sv
`timescale 1ns/1ps
module sim_chunk_dma;
  localparam int EXP_AW = 19;
  localparam logic [23:0] XM = 24'h07FFFF;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic cpu_we = 1'b0;
  logic [2:0] cpu_addr = 3'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic cpu_halt, bus_req, bus_gnt;
  logic [15:0] hm_addr;
  logic [7:0] hm_wdata, hm_rdata, xm_wdata, xm_rdata;
  logic hm_we, xm_we;
  logic [EXP_AW-1:0] xm_addr;

  chunk_dma #(.EXP_AW(EXP_AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_halt(cpu_halt),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .hm_addr(hm_addr),
    .hm_wdata(hm_wdata), .hm_we(hm_we), .hm_rdata(hm_rdata),
    .xm_addr(xm_addr), .xm_wdata(xm_wdata), .xm_we(xm_we), .xm_rdata(xm_rdata)
  );

  int nchk = 0, nerr = 0;
  int gdly = 0, gcnt = 0;
  always @(posedge clk) gcnt <= bus_req ? gcnt + 1 : 0;
  assign bus_gnt = bus_req && (gcnt > gdly);

  function automatic logic [7:0] hpat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] xpat(input logic [18:0] a);
    return (a[7:0] + 8'(a[15:8] * 3) + 8'(a[18:16] * 7)) ^ 8'hC3;
  endfunction

  always @(posedge clk) begin
    hm_rdata <= hpat(hm_addr);
    xm_rdata <= xpat(xm_addr);
  end

  logic [23:0] lg_a [4096];
  logic [7:0]  lg_d [4096];
  logic        lg_h [4096];
  int nlog = 0;
  always @(posedge clk) if (hm_we || xm_we) begin
    lg_a[nlog % 4096] <= hm_we ? {8'd0, hm_addr} : {5'd0, xm_addr};
    lg_d[nlog % 4096] <= hm_we ? hm_wdata : xm_wdata;
    lg_h[nlog % 4096] <= hm_we;
    nlog <= nlog + 1;
  end

  logic [15:0] th;
  logic [23:0] tx;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic setp(input logic [15:0] h, input logic [23:0] x);
    wr(3'd1, h[7:0]);  wr(3'd2, h[15:8]);
    wr(3'd3, x[7:0]);  wr(3'd4, x[15:8]); wr(3'd5, x[23:16]);
    th = h; tx = x;
  endtask

  task automatic check_ptrs(input string rq);
    logic [7:0] v;
    rd(3'd1, v); chk(rq, v, th[7:0]);
    rd(3'd2, v); chk(rq, v, th[15:8]);
    rd(3'd3, v); chk(rq, v, tx[7:0]);
    rd(3'd4, v); chk(rq, v, tx[15:8]);
    rd(3'd5, v); chk(rq, v, tx[23:16]);
  endtask

  task automatic run(input int code, input bit hold, input bit dir, input logic [1:0] rsv,
                     input int d, input bit intrude);
    int n, hc, base;
    logic [7:0] cv, v;
    n = 1 << code;
    gdly = d;
    cv = {rsv, dir, hold, 3'(code), 1'b1};
    @(negedge clk);
    base = nlog;
    wr(3'd0, cv);
    chk("R3 halt after go", {30'd0, cpu_halt, bus_req}, 32'd3);
    rd(3'd0, v); chk("R3 go bit busy", v[0], 1'b1);
    hc = 0;
    while (cpu_halt && hc < 2000) begin
      if (intrude) begin
        cpu_we = 1'b1; cpu_addr = 3'(hc % 6); cpu_wdata = 8'hA5 ^ 8'(hc);
      end
      hc++;
      @(negedge clk);
      cpu_we = 1'b0;
      if (cpu_halt) chk("R3 req with halt", bus_req, 1'b1);
    end
    cpu_we = 1'b0;
    chk("R3 req drops with halt", bus_req, 1'b0);
    chk("R11 halt length", hc, n + 3 + d);
    chk("R5 byte count", nlog - base, n);
    for (int k = 0; k < n; k++) begin
      logic [15:0] ha;
      logic [23:0] xa;
      ha = hold ? th : 16'(th + 16'(k));
      xa = (tx + 24'(k)) & XM;
      chk("R6 sink side", lg_h[(base + k) % 4096], dir);
      if (dir) begin
        chk(hold ? "R7 held host addr" : "R9 host addr", lg_a[(base + k) % 4096], {8'd0, ha});
        chk("R6 data exp->host", lg_d[(base + k) % 4096], xpat(xa[18:0]));
      end else begin
        chk("R9 exp addr", lg_a[(base + k) % 4096], xa);
        chk(hold ? "R7 held host data" : "R6 data host->exp", lg_d[(base + k) % 4096], hpat(ha));
      end
    end
    if (!hold) th = th + 16'(n);
    tx = (tx & ~XM) | ((tx + 24'(n)) & XM);
    rd(3'd0, v); chk("R3 go cleared, R2 bits kept", v, cv & 8'hFE);
    check_ptrs(intrude ? "R10 writes ignored, R8 ptrs" : "R8 advanced ptrs");
  endtask

  initial begin
    #(8 * 200000);
    nerr++; nchk++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1 reg reset", v, 8'd0);
    end
    chk("R1 halt/req/we", {28'd0, cpu_halt, bus_req, hm_we, xm_we}, 32'd0);

    // R2 readback, spare bits, no start without bit 0, addresses 6/7
    setp(16'h1234, 24'hABCDEF);
    check_ptrs("R2 readback");
    wr(3'd6, 8'h77); wr(3'd7, 8'h99);
    rd(3'd6, v); chk("R2 addr6 reads 0", v, 8'd0);
    rd(3'd7, v); chk("R2 addr7 reads 0", v, 8'd0);
    check_ptrs("R2 addr6/7 writes ignored");
    wr(3'd0, 8'hFE);
    repeat (6) @(negedge clk);
    rd(3'd0, v); chk("R2 ctrl readback", v, 8'hFE);
    chk("R2 no go, no halt", cpu_halt, 1'b0);
    chk("R2 no go, no writes", nlog, 0);

    // Sweep: every code, direction, hold; spare bits and grant delay varied
    setp(16'h4000, 24'h012300);
    for (int dir = 0; dir < 2; dir++)
      for (int hold = 0; hold < 2; hold++)
        for (int c = 0; c < 8; c++)
          run(c, hold[0], dir[0], 2'(c), c % 3, 1'b0);

    // R8 continuation: same control byte twice
    setp(16'h2000, 24'h000100);
    run(5, 1'b0, 1'b0, 2'd0, 0, 1'b0);
    run(5, 1'b0, 1'b0, 2'd0, 0, 1'b0);
    chk("R8 continued host ptr", {16'd0, th}, 32'h2040);
    chk("R8 continued exp ptr", {8'd0, tx}, 32'h000140);

    // R9 wraps, spare high bits kept
    setp(16'hFFF0, 24'hF7FFF0);
    run(5, 1'b0, 1'b1, 2'd3, 1, 1'b0);
    chk("R9 host wrap", {16'd0, th}, 32'h0010);
    chk("R9 exp wrap keeps spare bits", {8'd0, tx}, 32'hF00010);
    setp(16'hFFFC, 24'h0FFFFE);
    run(3, 1'b0, 1'b0, 2'd1, 0, 1'b0);
    setp(16'hFFFF, 24'hFFFFFF);
    run(7, 1'b1, 1'b1, 2'd2, 2, 1'b0);

    // R10 register writes during transfer
    setp(16'h3000, 24'h050000);
    run(4, 1'b0, 1'b1, 2'd0, 2, 1'b1);
    run(0, 1'b1, 1'b0, 2'd2, 0, 1'b1);
    run(7, 1'b0, 1'b0, 2'd1, 4, 1'b1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule